// File: doc/BRIEF.md
# Inbound Address Window Decoder

This block sits behind the receive side of a PCIe endpoint port. It turns a memory address that arrives from the link into three things: an internal target identifier, an attribute byte and a translated address. If no window claims the address, it raises a miss flag instead. Software sets it up through a small register bus. That bus holds one aperture register pair, which gates the whole inbound range, and a set of decode windows. Each window has a control word, a base and a remap value.

All sizes and bases work at 64 KB granularity, so only the upper sixteen address bits take part in any comparison. The aperture size must be a power of two. If software writes a size that is not a power of two, the hardware uses the next larger power of two. When several windows claim the same address, the lowest-numbered one wins. A lookup is presented with a valid strobe, and its result appears registered on the next clock edge.

Top module: `inb_win_decoder`

## Requirements
- R1: After reset every window control, base and remap register and both aperture registers read zero, and every lookup reports a miss.
- R2: A window control word keeps only size-minus-one in bits 31:16, attribute in bits 15:8, target in bits 7:4 and enable in bit 0; bits 3:1 read zero. Window base, window remap and aperture base keep only bits 31:16; aperture control keeps bits 31:16 and bit 0.
- R3: Aperture base sits at offset 0x00 and aperture control at 0x04. Windows 0 to 4 sit at 0x20 plus 16 times the index, and window 5 at 0x80. Inside each window, control is at +0x0, base at +0x4 and remap at +0xC. Reads of any other offset return zero.
- R4: A lookup can hit only when aperture control bit 0 is set and the address lies inside the aperture. Otherwise it misses, whatever the windows hold.
- R5: If the aperture size-minus-one field is not of the form 2^k-1, it is rounded up to the next such value.
- R6: Window n claims an address when its enable bit is set and (address AND NOT mask) equals its base, where mask is {size-minus-one, 16'hFFFF}.
- R7: When several windows claim an address, the lowest-numbered one is used. Disabling it hands the address to the next claimant.
- R8: A hit reports the chosen window's target and attribute with the miss flag low. A miss raises the flag and reports zero target, attribute and address.
- R9: A nonzero remap gives (remap AND NOT mask) OR (address AND mask). A zero remap passes the address through unchanged.
- R10: The result valid is high exactly one cycle after each cycle in which the lookup valid is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Inbound address to decode |
| res_valid | output | 1 | Lookup result valid |
| res_miss | output | 1 | No window claimed the address |
| res_target | output | 4 | Target identifier of the claiming window |
| res_attr | output | 8 | Attribute byte of the claiming window |
| res_addr | output | 32 | Translated address |

## Verification
A corrupted window or aperture register shows up on the next lookup that touches that window, one cycle after the strobe. It appears as a wrong target, a wrong translated address or a false miss. It also shows at once on a register read of that offset. A wrong priority choice shows only on addresses where windows overlap, so the stimulus deliberately nests one window inside another. A missed rounding of the aperture size shows only on addresses that lie inside the rounded aperture but outside the raw field's bit pattern, so one address is picked to sit in that gap.

// File: rtl/inb_win_pkg.sv
package inb_win_pkg;

    localparam int ADDR_W = 32;
    localparam int GRAN_W = 16;
    localparam int HI_W   = ADDR_W - GRAN_W;
    localparam int ATTR_W = 8;
    localparam int TGT_W  = 4;

    typedef struct packed {
        logic [HI_W-1:0]   size_m1;
        logic [ATTR_W-1:0] attr;
        logic [TGT_W-1:0]  tgt;
        logic              en;
    } win_ctrl_t;

    // Round a size-minus-one field up to the form 2^k-1 by smearing ones downward.
    function automatic logic [HI_W-1:0] smear_down(input logic [HI_W-1:0] v);
        logic [HI_W-1:0] r;
        r = v;
        for (int i = HI_W - 2; i >= 0; i--) begin
            r[i] = r[i] | r[i+1];
        end
        return r;
    endfunction

endpackage

// File: rtl/inb_win_regs.sv
module inb_win_regs
    import inb_win_pkg::*;
#(
    parameter int NUM_WIN     = 6,
    parameter int NUM_STRIDED = 5,
    parameter int RAW         = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [RAW-1:0]              reg_addr,
    input  logic [ADDR_W-1:0]           reg_wdata,
    output logic [ADDR_W-1:0]           reg_rdata,
    output win_ctrl_t [NUM_WIN-1:0]     win_ctrl,
    output logic [NUM_WIN-1:0][HI_W-1:0] win_base,
    output logic [NUM_WIN-1:0][HI_W-1:0] win_remap,
    output logic [HI_W-1:0]             bar_base,
    output logic [HI_W-1:0]             bar_size,
    output logic                        bar_en
);

    localparam int OFF_BAR_BASE = 'h00;
    localparam int OFF_BAR_CTRL = 'h04;
    localparam int OFF_STRIDED  = 'h20;
    localparam int OFF_EXTRA    = 'h80;
    localparam int STRIDE       = 16;
    localparam int SEL_CTRL     = 'h0;
    localparam int SEL_BASE     = 'h4;
    localparam int SEL_REMAP    = 'hC;

    function automatic logic [RAW-1:0] win_off(input int idx, input int sel);
        int o;
        if (idx < NUM_STRIDED) o = OFF_STRIDED + STRIDE * idx + sel;
        else                   o = OFF_EXTRA + STRIDE * (idx - NUM_STRIDED) + sel;
        return RAW'(o);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_ctrl  <= '0;
            win_base  <= '0;
            win_remap <= '0;
            bar_base  <= '0;
            bar_size  <= '0;
            bar_en    <= 1'b0;
        end else if (reg_we) begin
            if (reg_addr == RAW'(OFF_BAR_BASE)) bar_base <= reg_wdata[ADDR_W-1:GRAN_W];
            if (reg_addr == RAW'(OFF_BAR_CTRL)) begin
                bar_size <= reg_wdata[ADDR_W-1:GRAN_W];
                bar_en   <= reg_wdata[0];
            end
            for (int i = 0; i < NUM_WIN; i++) begin
                if (reg_addr == win_off(i, SEL_CTRL)) begin
                    win_ctrl[i].size_m1 <= reg_wdata[31:16];
                    win_ctrl[i].attr    <= reg_wdata[15:8];
                    win_ctrl[i].tgt     <= reg_wdata[7:4];
                    win_ctrl[i].en      <= reg_wdata[0];
                end
                if (reg_addr == win_off(i, SEL_BASE))  win_base[i]  <= reg_wdata[ADDR_W-1:GRAN_W];
                if (reg_addr == win_off(i, SEL_REMAP)) win_remap[i] <= reg_wdata[ADDR_W-1:GRAN_W];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == RAW'(OFF_BAR_BASE)) reg_rdata = {bar_base, {GRAN_W{1'b0}}};
        if (reg_addr == RAW'(OFF_BAR_CTRL)) reg_rdata = {bar_size, {(GRAN_W-1){1'b0}}, bar_en};
        for (int i = 0; i < NUM_WIN; i++) begin
            if (reg_addr == win_off(i, SEL_CTRL))
                reg_rdata = {win_ctrl[i].size_m1, win_ctrl[i].attr, win_ctrl[i].tgt, 3'b000, win_ctrl[i].en};
            if (reg_addr == win_off(i, SEL_BASE))  reg_rdata = {win_base[i],  {GRAN_W{1'b0}}};
            if (reg_addr == win_off(i, SEL_REMAP)) reg_rdata = {win_remap[i], {GRAN_W{1'b0}}};
        end
    end

endmodule

// File: rtl/inb_win_match.sv
module inb_win_match
    import inb_win_pkg::*;
#(
    parameter int NUM_WIN = 6
) (
    input  logic [ADDR_W-1:0]            addr,
    input  win_ctrl_t [NUM_WIN-1:0]      win_ctrl,
    input  logic [NUM_WIN-1:0][HI_W-1:0] win_base,
    input  logic [HI_W-1:0]              bar_base,
    input  logic [HI_W-1:0]              bar_size,
    input  logic                         bar_en,
    output logic                         bar_ok,
    output logic [NUM_WIN-1:0]           hit
);

    logic [HI_W-1:0] addr_hi;
    logic [HI_W-1:0] bar_mask;

    assign addr_hi  = addr[ADDR_W-1:GRAN_W];
    assign bar_mask = smear_down(bar_size);
    assign bar_ok   = bar_en && (((addr_hi ^ bar_base) & ~bar_mask) == '0);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic claim;
        assign claim  = win_ctrl[g].en && ((addr_hi & ~win_ctrl[g].size_m1) == win_base[g]);
        assign hit[g] = claim && bar_ok;
    end

endmodule

// File: rtl/inb_win_prio.sv
module inb_win_prio #(
    parameter int NUM_WIN = 6,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic [NUM_WIN-1:0] hit,
    output logic [NUM_WIN-1:0] grant,
    output logic [IDX_W-1:0]   sel,
    output logic               any
);

    always_comb begin
        grant = '0;
        sel   = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                sel      = IDX_W'(i);
            end
        end
    end

    assign any = |hit;

endmodule

// File: rtl/inb_win_decoder.sv
module inb_win_decoder
    import inb_win_pkg::*;
#(
    parameter int NUM_WIN     = 6,
    parameter int NUM_STRIDED = 5,
    parameter int RAW         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RAW-1:0]    reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lk_valid,
    input  logic [31:0]       lk_addr,
    output logic              res_valid,
    output logic              res_miss,
    output logic [3:0]        res_target,
    output logic [7:0]        res_attr,
    output logic [31:0]       res_addr
);

    localparam int IDX_W = $clog2(NUM_WIN);

    win_ctrl_t [NUM_WIN-1:0]      win_ctrl;
    logic [NUM_WIN-1:0][HI_W-1:0] win_base;
    logic [NUM_WIN-1:0][HI_W-1:0] win_remap;
    logic [HI_W-1:0]              bar_base;
    logic [HI_W-1:0]              bar_size;
    logic                         bar_en;
    logic                         bar_ok;
    logic [NUM_WIN-1:0]           hit;
    logic [NUM_WIN-1:0]           grant;
    logic [IDX_W-1:0]             sel;
    logic                         any;

    inb_win_regs #(.NUM_WIN(NUM_WIN), .NUM_STRIDED(NUM_STRIDED), .RAW(RAW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .win_ctrl(win_ctrl), .win_base(win_base), .win_remap(win_remap),
        .bar_base(bar_base), .bar_size(bar_size), .bar_en(bar_en)
    );

    inb_win_match #(.NUM_WIN(NUM_WIN)) u_match (
        .addr(lk_addr), .win_ctrl(win_ctrl), .win_base(win_base),
        .bar_base(bar_base), .bar_size(bar_size), .bar_en(bar_en),
        .bar_ok(bar_ok), .hit(hit)
    );

    inb_win_prio #(.NUM_WIN(NUM_WIN)) u_prio (
        .hit(hit), .grant(grant), .sel(sel), .any(any)
    );

    win_ctrl_t         ctrl_sel;
    logic [HI_W-1:0]   remap_sel;
    logic [ADDR_W-1:0] win_mask;
    logic [ADDR_W-1:0] xlat;

    always_comb begin
        ctrl_sel  = win_ctrl[sel];
        remap_sel = win_remap[sel];
        win_mask  = {ctrl_sel.size_m1, {GRAN_W{1'b1}}};
        if (remap_sel == '0) xlat = lk_addr;
        else                 xlat = ({remap_sel, {GRAN_W{1'b0}}} & ~win_mask) | (lk_addr & win_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_miss   <= 1'b0;
            res_target <= '0;
            res_attr   <= '0;
            res_addr   <= '0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                res_miss   <= !any;
                res_target <= any ? ctrl_sel.tgt  : '0;
                res_attr   <= any ? ctrl_sel.attr : '0;
                res_addr   <= any ? xlat          : '0;
            end
        end
    end

endmodule

// File: rtl/inb_win_chk.sv
module inb_win_chk #(
    parameter int NUM_WIN = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               res_valid,
    input logic               res_miss,
    input logic [3:0]         res_target,
    input logic [7:0]         res_attr,
    input logic [31:0]        res_addr,
    input logic               bar_en,
    input logic [NUM_WIN-1:0] hit,
    input logic [NUM_WIN-1:0] grant
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> res_valid); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |=> !res_valid); // R10
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_miss) |-> (res_target == '0 && res_attr == '0 && res_addr == '0)); // R8
    AST_BAR_GATE: assert property (@(posedge clk) disable iff (!rst_n) (lk_valid && !bar_en) |=> res_miss); // R4
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant)); // R7
    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |-> ((grant & hit) == grant && grant != '0 && ((grant - 1'b1) & hit) == '0)); // R7

endmodule

bind inb_win_decoder inb_win_chk #(.NUM_WIN(NUM_WIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .res_valid(res_valid),
    .res_miss(res_miss), .res_target(res_target), .res_attr(res_attr),
    .res_addr(res_addr), .bar_en(bar_en), .hit(hit), .grant(grant)
);

// File: tb/test_inb_win_decoder.sv
`timescale 1ns/1ps
module test_inb_win_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        res_valid, res_miss;
    logic [3:0]  res_target;
    logic [7:0]  res_attr;
    logic [31:0] res_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    inb_win_decoder i_inb_win_decoder (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .res_valid(res_valid), .res_miss(res_miss),
        .res_target(res_target), .res_attr(res_attr), .res_addr(res_addr)
    );

    // {address, miss, target, attr, translated address}
    localparam int NV = 12;
    localparam logic [76:0] VEC [NV] = '{
        {32'h0012_3456, 1'b0, 4'h3, 8'h0E, 32'h0012_3456},
        {32'h0030_0010, 1'b0, 4'h5, 8'h1D, 32'h0030_0010},
        {32'h0234_5678, 1'b0, 4'h7, 8'h0D, 32'h8034_5678},
        {32'h0400_BEEF, 1'b0, 4'hC, 8'hAA, 32'h1230_BEEF},
        {32'h0401_0000, 1'b1, 4'h0, 8'h00, 32'h0000_0000},
        {32'h0100_0000, 1'b1, 4'h0, 8'h00, 32'h0000_0000},
        {32'h1000_0004, 1'b1, 4'h0, 8'h00, 32'h0000_0000},
        {32'h0010_0000, 1'b0, 4'h3, 8'h0E, 32'h0010_0000},
        {32'h000F_FFFF, 1'b0, 4'h5, 8'h1D, 32'h000F_FFFF},
        {32'h0600_1234, 1'b0, 4'hB, 8'h44, 32'h0600_1234},
        {32'h001F_FFFF, 1'b0, 4'h3, 8'h0E, 32'h001F_FFFF},
        {32'h0020_0000, 1'b0, 4'h5, 8'h1D, 32'h0020_0000}
    };

    function automatic void check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic look(input logic [31:0] a, input bit m, input logic [3:0] t,
                        input logic [7:0] at, input logic [31:0] x, input string tag);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        check(res_valid == 1'b1 && res_miss == m, {tag, " valid/miss"}, {62'd0, res_valid, res_miss}, {62'd0, 1'b1, m});
        check(res_target == t && res_attr == at, {tag, " target/attr"}, {52'd0, res_target, res_attr}, {52'd0, t, at});
        check(res_addr == x, {tag, " address"}, 64'(res_addr), 64'(x));
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h04, 32'h0, "R1 aperture control");
        rd(8'h20, 32'h0, "R1 window0 control");
        rd(8'h80, 32'h0, "R1 window5 control");
        look(32'h0000_1000, 1'b1, 4'h0, 8'h00, 32'h0, "R1 lookup after reset");

        // R2 field masking, R3 offsets
        wr(8'h60, 32'hFFFF_FFFF);
        rd(8'h60, 32'hFFFF_FFF1, "R2 control field mask");
        wr(8'h64, 32'hFFFF_FFFF);
        rd(8'h64, 32'hFFFF_0000, "R2 base field mask");
        wr(8'h6C, 32'h1234_5678);
        rd(8'h6C, 32'h1234_0000, "R2 remap field mask");
        wr(8'h04, 32'h0FFF_FFFF);
        rd(8'h04, 32'h0FFF_0001, "R2 aperture control mask");
        rd(8'h08, 32'h0, "R3 unmapped offset");
        rd(8'h68, 32'h0, "R3 unmapped window slot");
        wr(8'h60, 32'h0); wr(8'h64, 32'h0); wr(8'h6C, 32'h0);

        // configuration
        wr(8'h00, 32'h0000_0000);
        wr(8'h04, 32'h0FFF_0001);
        wr(8'h20, 32'h000F_0E31); wr(8'h24, 32'h0010_0000); wr(8'h2C, 32'h0);
        wr(8'h30, 32'h003F_1D51); wr(8'h34, 32'h0000_0000); wr(8'h3C, 32'h0);
        wr(8'h40, 32'h00FF_0D71); wr(8'h44, 32'h0200_0000); wr(8'h4C, 32'h8000_0000);
        wr(8'h50, 32'h000F_3391); wr(8'h54, 32'h1000_0000); wr(8'h5C, 32'h0);
        wr(8'h60, 32'h0000_44B1); wr(8'h64, 32'h0600_0000); wr(8'h6C, 32'h0);
        wr(8'h80, 32'h0000_AAC1); wr(8'h84, 32'h0400_0000); wr(8'h8C, 32'h1230_0000);
        rd(8'h80, 32'h0000_AAC1, "R3 window5 control offset");
        rd(8'h44, 32'h0200_0000, "R3 window2 base offset");
        rd(8'h8C, 32'h1230_0000, "R3 window5 remap offset");

        // table: R6 hits, R7 nesting, R8 misses, R9 remap, R4 out of aperture
        for (int v = 0; v < NV; v++) begin
            look(VEC[v][76:45], VEC[v][44], VEC[v][43:40], VEC[v][39:32], VEC[v][31:0],
                 $sformatf("R6/R8/R9 vector %0d", v));
        end

        // R10 idle cycle
        @(negedge clk);
        check(res_valid == 1'b0, "R10 valid low when idle", 64'(res_valid), 64'd0);

        // R5 rounding: field 0x0900 covers 0x0600_xxxx only when rounded up
        wr(8'h04, 32'h0900_0001);
        look(32'h0600_1234, 1'b0, 4'hB, 8'h44, 32'h0600_1234, "R5 rounded aperture");
        look(32'h1000_0004, 1'b1, 4'h0, 8'h00, 32'h0, "R4 beyond rounded aperture");

        // R4 wider aperture reaches window3
        wr(8'h04, 32'h1000_0001);
        look(32'h1000_0004, 1'b0, 4'h9, 8'h33, 32'h1000_0004, "R4 widened aperture");

        // R4 aperture disabled
        wr(8'h04, 32'h0FFF_0000);
        look(32'h0012_3456, 1'b1, 4'h0, 8'h00, 32'h0, "R4 aperture disabled");

        // R7 fallback when lower window disabled
        wr(8'h04, 32'h0FFF_0001);
        wr(8'h20, 32'h000F_0E30);
        look(32'h0012_3456, 1'b0, 4'h5, 8'h1D, 32'h0012_3456, "R7 fallback to window1");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule